// File: doc/BRIEF.md
# Shared Memory with Processor-Priority Arbitration

This block is a word-wide memory shared by two synchronous ports on one clock. The processor port reads and writes with no wait state and is never held off. The display-refresh port only reads. A display access is cancelled outright when both ports are selected in the same cycle at the same address. The processor access then goes ahead. The display side keeps the word it returned last, so it may show stale data for that fetch, and no retry is issued.

Each display suppression produces a one-cycle clash pulse, aligned with the cycle in which read data would have returned. The storage depth is set by `ADDR_W`: the deployed configuration uses `ADDR_W = 13` and `DATA_W = 16`, which gives 8192 words. Reads on both ports are registered and have one cycle of latency. The array contents are not reset.

Top module: `shared_mem_arb`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits, and every address from 0 to 2**ADDR_W-1, including the highest, can be written and read back.
- R2: When cpu_sel=1 and cpu_wr=1 at a rising edge, cpu_wdata is stored at cpu_addr on that edge, with no wait state.
- R3: When cpu_sel=1 and cpu_wr=0 at a rising edge, cpu_rdata shows the word at cpu_addr from that edge onward. This holds in every case, including contention.
- R4: Contention exists only when cpu_sel=1, disp_sel=1 and cpu_addr equals disp_addr. The value of cpu_wr does not matter.
- R5: On contention the display access is suppressed in the same cycle, and disp_rdata keeps its previous value.
- R6: clash_o is 1 for exactly the one cycle that follows an edge at which contention existed, and is 0 otherwise.
- R7: A display read with disp_sel=1 and no contention returns the word at disp_addr on disp_rdata one cycle later. A processor write at a different address in the same cycle also completes, and the display sees the old word.
- R8: A port whose select is 0 at an edge keeps its read data unchanged.
- R9: While rst_n=0, cpu_rdata and disp_rdata are 0 and clash_o is 0.
- R10: A processor write made during contention is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| cpu_sel | input | 1 | Processor port select |
| cpu_wr | input | 1 | Processor write enable (1 = write, 0 = read) |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Processor read data, one cycle after the request |
| disp_sel | input | 1 | Display port read select |
| disp_addr | input | ADDR_W | Display word address |
| disp_rdata | output | DATA_W | Display read data; holds its value when the access is suppressed |
| clash_o | output | 1 | One-cycle pulse marking a suppressed display access |

## Verification
The bench builds the block with `ADDR_W = 6` and `DATA_W = 16`. With 64 words, the bottom and top addresses and a scoreboard of the whole array are cheap to cover, while the address comparison still spans several bits. Both read-read and write-read contention are driven after the display output has been primed with a known word. This way the hold of disp_rdata and the landing of the processor write can both be seen at the ports.

// File: rtl/shm_pkg.sv
package shm_pkg;

  localparam int SHM_MAX_AW = 32;

  typedef logic [SHM_MAX_AW-1:0] shm_addr_t;

  // Contention: both selected and identical word addresses.
  function automatic logic addr_clash(input logic sel_a, input logic sel_b,
                                      input shm_addr_t addr_a, input shm_addr_t addr_b);
    return sel_a && sel_b && (addr_a == addr_b);
  endfunction

endpackage

// File: rtl/shm_contention.sv
module shm_contention #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              disp_sel,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [ADDR_W-1:0] disp_addr,
  output logic              collide,
  output logic              disp_grant,
  output logic              clash_q
);
  import shm_pkg::*;

  always_comb begin
    collide    = addr_clash(cpu_sel, disp_sel,
                            shm_addr_t'(cpu_addr), shm_addr_t'(disp_addr));
    disp_grant = disp_sel && !collide;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) clash_q <= 1'b0;
    else        clash_q <= collide;
  end

  // R5: a suppressed display access is never granted
  assert_gate_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && disp_sel && cpu_addr == disp_addr) |-> !disp_grant);

  // R4: without both selects there is no contention
  assert_needs_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_sel || !disp_sel) |-> !collide);

endmodule

// File: rtl/shm_array.sv
module shm_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic a_wr, a_rd;

  assign a_wr = a_en && a_we;
  assign a_rd = a_en && !a_we;

  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= mem[a_addr];
      if (b_en) b_rdata <= mem[b_addr];
    end
  end

  // R2: a processor write lands on the edge it is presented
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr |=> (mem[$past(a_addr)] == $past(a_wdata)));

  // R3: a processor read returns the stored word next cycle
  assert_cpu_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd && $past(rst_n)) |=> (a_rdata == $past(mem[a_addr])));

  // R8: an idle display port holds its data
  assert_disp_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_en && $past(rst_n)) |=> $stable(b_rdata));

endmodule

// File: rtl/shared_mem_arb.sv
module shared_mem_arb #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              disp_sel,
  input  logic [ADDR_W-1:0] disp_addr,
  output logic [DATA_W-1:0] disp_rdata,
  output logic              clash_o
);

  logic collide;
  logic disp_grant;

  shm_contention #(.ADDR_W(ADDR_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_sel    (cpu_sel),
    .disp_sel   (disp_sel),
    .cpu_addr   (cpu_addr),
    .disp_addr  (disp_addr),
    .collide    (collide),
    .disp_grant (disp_grant),
    .clash_q    (clash_o)
  );

  shm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_en    (cpu_sel),
    .a_we    (cpu_wr),
    .a_addr  (cpu_addr),
    .a_wdata (cpu_wdata),
    .a_rdata (cpu_rdata),
    .b_en    (disp_grant),
    .b_addr  (disp_addr),
    .b_rdata (disp_rdata)
  );

  // R6: the clash pulse follows exactly one contention edge
  assert_clash_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && disp_sel && cpu_addr == disp_addr) |=> clash_o);

  assert_clash_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_sel && disp_sel && cpu_addr == disp_addr) |=> !clash_o);

  // R5: display data frozen across a suppressed access
  assert_disp_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && $past(rst_n)) |=> $stable(disp_rdata));

  // R9: outputs cleared while in reset
  assert_reset_state_R9: assert property (@(posedge clk)
    $past(!rst_n) |-> (cpu_rdata == '0 && disp_rdata == '0 && !clash_o));

endmodule

// File: tb/tb_shared_mem_arb.sv
module tb_shared_mem_arb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_sel, cpu_wr, disp_sel;
  logic [AW-1:0] cpu_addr, disp_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, disp_rdata;
  logic          clash_o;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] model [N];

  always #2 clk = ~clk;

  shared_mem_arb #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .disp_sel(disp_sel), .disp_addr(disp_addr), .disp_rdata(disp_rdata),
    .clash_o(clash_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, then sample just after the edge.
  task automatic cyc(input logic cs, input logic we, input logic [AW-1:0] ca,
                     input logic [DW-1:0] wd, input logic ds, input logic [AW-1:0] da);
    cpu_sel = cs; cpu_wr = we; cpu_addr = ca; cpu_wdata = wd;
    disp_sel = ds; disp_addr = da;
    @(posedge clk); #1;
    if (cs && we) model[ca] = wd;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, '0, '0, 1'b0, '0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cyc(1'b1, 1'b0, 6'd1, 16'h0, 1'b1, 6'd2);
    cyc(1'b0, 1'b0, '0, '0, 1'b0, '0);
    chk("R9 cpu_rdata", 32'(cpu_rdata), 32'h0);
    chk("R9 disp_rdata", 32'(disp_rdata), 32'h0);
    chk("R9 clash_o", 32'(clash_o), 32'h0);
    rst_n = 1'b1;
    idle();
  endtask

  task automatic t_fill_and_read();
    for (int i = 0; i < N; i++) cyc(1'b1, 1'b1, AW'(i), DW'(16'hA500 ^ (i * 37)), 1'b0, '0);
    idle();
    chk("R6 idle clash", 32'(clash_o), 32'h0);
    cyc(1'b1, 1'b0, 6'd0, '0, 1'b0, '0);
    chk("R1 R3 read addr 0", 32'(cpu_rdata), 32'(model[0]));
    cyc(1'b1, 1'b0, 6'd63, '0, 1'b0, '0);
    chk("R1 R3 read top addr", 32'(cpu_rdata), 32'(model[63]));
    cyc(1'b1, 1'b0, 6'd21, '0, 1'b0, '0);
    chk("R2 R3 read addr 21", 32'(cpu_rdata), 32'(model[21]));
  endtask

  task automatic t_disp_read();
    cyc(1'b0, 1'b0, '0, '0, 1'b1, 6'd63);
    chk("R7 disp top addr", 32'(disp_rdata), 32'(model[63]));
    cyc(1'b0, 1'b0, '0, '0, 1'b1, 6'd9);
    chk("R7 disp addr 9", 32'(disp_rdata), 32'(model[9]));
  endtask

  task automatic t_concurrent();
    logic [DW-1:0] old9;
    old9 = model[9];
    cyc(1'b1, 1'b1, 6'd5, 16'h1234, 1'b1, 6'd9);
    chk("R7 disp during cpu write", 32'(disp_rdata), 32'(old9));
    chk("R6 no clash diff addr", 32'(clash_o), 32'h0);
    cyc(1'b1, 1'b0, 6'd5, '0, 1'b0, '0);
    chk("R7 concurrent write landed", 32'(cpu_rdata), 32'h1234);
  endtask

  task automatic t_contention_rr();
    logic [DW-1:0] held;
    cyc(1'b0, 1'b0, '0, '0, 1'b1, 6'd40);
    held = model[40];
    cyc(1'b1, 1'b0, 6'd3, '0, 1'b1, 6'd3);
    chk("R3 cpu read under contention", 32'(cpu_rdata), 32'(model[3]));
    chk("R5 disp held read-read", 32'(disp_rdata), 32'(held));
    chk("R4 R6 clash read-read", 32'(clash_o), 32'h1);
    idle();
    chk("R6 clash single cycle", 32'(clash_o), 32'h0);
    chk("R8 disp idle hold", 32'(disp_rdata), 32'(held));
  endtask

  task automatic t_contention_wr();
    logic [DW-1:0] held;
    cyc(1'b0, 1'b0, '0, '0, 1'b1, 6'd50);
    held = model[50];
    cyc(1'b1, 1'b1, 6'd7, 16'hBEEF, 1'b1, 6'd7);
    chk("R4 R6 clash write-read", 32'(clash_o), 32'h1);
    chk("R5 disp held write-read", 32'(disp_rdata), 32'(held));
    cyc(1'b1, 1'b0, 6'd7, '0, 1'b0, '0);
    chk("R10 write under contention", 32'(cpu_rdata), 32'hBEEF);
    cyc(1'b0, 1'b0, '0, '0, 1'b1, 6'd7);
    chk("R7 disp sees new word", 32'(disp_rdata), 32'hBEEF);
  endtask

  task automatic t_one_side();
    logic [DW-1:0] cpu_prev;
    cyc(1'b1, 1'b0, 6'd12, '0, 1'b0, '0);
    cpu_prev = cpu_rdata;
    cyc(1'b0, 1'b0, 6'd12, '0, 1'b1, 6'd12);
    chk("R4 no clash cpu unselected", 32'(clash_o), 32'h0);
    chk("R4 disp served same addr", 32'(disp_rdata), 32'(model[12]));
    chk("R8 cpu idle hold", 32'(cpu_rdata), 32'(cpu_prev));
    cyc(1'b1, 1'b0, 6'd13, '0, 1'b1, 6'd12);
    chk("R4 adjacent addr no clash", 32'(clash_o), 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    cpu_sel = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    disp_sel = 1'b0; disp_addr = '0;
    t_reset();
    t_fill_and_read();
    t_disp_read();
    t_concurrent();
    t_contention_rr();
    t_contention_wr();
    t_one_side();
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule